// File: doc/BRIEF.md
# Conservative Load-Store Queue

This block is the memory-instruction queue of an out-of-order core. Loads and stores enter it in program order next to the general issue queue. Each entry waits for its base register through a tag broadcast bus. Once the base is known, the entry forms its effective address as base value plus a sign-extended immediate. Only then does the entry compete for a single memory request port. Stores also wait for their data register, which arrives the same way.

Memory access is gated by conservative address disambiguation. A load goes to memory only when every older store still in the queue has a resolved address that differs from the load's address. Loads to distinct resolved addresses may therefore pass each other, and may pass older stores to other addresses. A store goes out only when it is the oldest entry in the queue.

When several entries are eligible in the same cycle, the oldest one wins. A memory response names the queue entry it answers, and the block then returns that load's destination tag. Entries leave from the head in program order once their access is complete.

Top module: `lsq_core`

## Requirements
- R1: After reset the queue is empty: `lsq_full` is 0 and `mem_req_valid` is 0.
- R2: `lsq_full` is 1 when all DEPTH entries are occupied. While it is 1, an allocation attempt is dropped, and the dropped instruction never produces a memory request.
- R3: A broadcast whose tag matches a waiting base or data tag delivers its value to that entry. This includes a broadcast in the same cycle as the entry's allocation.
- R4: The request address is base value plus the immediate sign-extended from IMM_W bits, modulo 2^DATA_W. The request is held while `mem_req_ready` is 0.
- R5: A load issues no request while an older, not yet issued store has an unknown address.
- R6: A load waits behind an older unissued store with an equal address. It proceeds once that store has issued. A load issues past an older store whose address differs.
- R7: A store requests only when it is the oldest entry in the queue and its data is ready. A store with an older load still in the queue waits until that load has completed and left.
- R8: Among eligible entries the oldest is requested first, and at most one request is made per cycle.
- R9: In the cycle of `mem_resp_valid`, `ld_wb_valid` is 1 and `ld_wb_tag` carries the destination tag of the load in entry `mem_resp_idx`. Responses may come in any order.
- R10: Entries leave only from the head, one per cycle, once their access is complete. A completed younger load does not free a slot while the head entry is still waiting.
- R11: Each entry issues at most one request. `mem_req_tag` carries the load's destination tag or the store's data tag, and `mem_req_wdata` carries the store data. `mem_req_store` is 1 for a store and 0 for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Allocate one instruction at the tail |
| alloc_is_store | input | 1 | 1 = store, 0 = load |
| alloc_base_tag | input | TAG_W | Base register tag |
| alloc_base_rdy | input | 1 | Base value already available |
| alloc_base_val | input | DATA_W | Base value when ready |
| alloc_imm | input | IMM_W | Signed address offset |
| alloc_aux_tag | input | TAG_W | Load destination tag or store data tag |
| alloc_aux_rdy | input | 1 | Store data already available (ignored for loads) |
| alloc_aux_val | input | DATA_W | Store data when ready |
| lsq_full | output | 1 | All entries occupied; allocation refused |
| bc_valid | input | 1 | Tag broadcast valid |
| bc_tag | input | TAG_W | Broadcast register tag |
| bc_data | input | DATA_W | Broadcast register value |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_store | output | 1 | Request is a store |
| mem_req_addr | output | DATA_W | Effective address |
| mem_req_wdata | output | DATA_W | Store data |
| mem_req_tag | output | TAG_W | Destination or data tag of the entry |
| mem_req_idx | output | log2(DEPTH) | Queue entry making the request |
| mem_resp_valid | input | 1 | Load response |
| mem_resp_idx | input | log2(DEPTH) | Entry the response belongs to |
| ld_wb_valid | output | 1 | Load completion |
| ld_wb_tag | output | TAG_W | Destination tag of the completed load |

## Verification
The assertions assume a well-behaved environment. A response names only an entry whose load request was accepted and not yet answered, with at most one response per load. Broadcast tags never collide with live tags of another meaning. The stimulus respects this by keeping a per-entry record of accepted loads and answering only from that record, one response per cycle. Each scenario uses its own fresh range of tag numbers. Allocation stays at one instruction per cycle, and the test tries to allocate while full only in the one case written for that.

// File: rtl/lsq_pkg.sv
`timescale 1ns/1ps
package lsq_pkg;
  typedef enum logic {
    MOP_LOAD  = 1'b0,
    MOP_STORE = 1'b1
  } mop_e;
endpackage

// File: rtl/lsq_entry.sv
`timescale 1ns/1ps
module lsq_entry #(
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  lsq_pkg::mop_e     alloc_op,
  input  logic [TAG_W-1:0]  alloc_base_tag,
  input  logic              alloc_base_rdy,
  input  logic [DATA_W-1:0] alloc_base_val,
  input  logic [IMM_W-1:0]  alloc_imm,
  input  logic [TAG_W-1:0]  alloc_aux_tag,
  input  logic              alloc_aux_rdy,
  input  logic [DATA_W-1:0] alloc_aux_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  input  logic              issue_en,
  input  logic              resp_en,
  input  logic              free_en,
  output logic              e_valid,
  output logic              e_store,
  output logic              e_addr_vld,
  output logic [DATA_W-1:0] e_addr,
  output logic              e_dat_rdy,
  output logic [DATA_W-1:0] e_dat,
  output logic [TAG_W-1:0]  e_tag,
  output logic              e_issued,
  output logic              e_done
);
  import lsq_pkg::*;

  localparam int EXT_W = DATA_W - IMM_W;

  // control state (reset)
  logic valid_q, valid_d, brdy_q, brdy_d, ardy_q, ardy_d;
  logic avld_q, avld_d, iss_q, iss_d, done_q, done_d;
  // payload state (no reset)
  mop_e              op_q, op_d;
  logic [TAG_W-1:0]  btag_q, btag_d, atag_q, atag_d;
  logic [DATA_W-1:0] bval_q, bval_d, aval_q, aval_d, addr_q, addr_d;
  logic [IMM_W-1:0]  imm_q, imm_d;
  logic              pay_en;

  logic hit_alloc_base, hit_alloc_aux, hit_base, hit_aux;
  assign hit_alloc_base = bc_valid && (bc_tag == alloc_base_tag);
  assign hit_alloc_aux  = bc_valid && (bc_tag == alloc_aux_tag);
  assign hit_base       = bc_valid && (bc_tag == btag_q) && !brdy_q;
  assign hit_aux        = bc_valid && (bc_tag == atag_q) && !ardy_q;

  always_comb begin
    valid_d = valid_q; brdy_d = brdy_q; ardy_d = ardy_q;
    avld_d  = avld_q;  iss_d  = iss_q;  done_d = done_q;
    op_d    = op_q;    btag_d = btag_q; atag_d = atag_q;
    bval_d  = bval_q;  aval_d = aval_q; addr_d = addr_q; imm_d = imm_q;
    if (alloc_en) begin
      valid_d = 1'b1;
      op_d    = alloc_op;
      btag_d  = alloc_base_tag;
      brdy_d  = alloc_base_rdy || hit_alloc_base;
      bval_d  = alloc_base_rdy ? alloc_base_val : bc_data;
      imm_d   = alloc_imm;
      atag_d  = alloc_aux_tag;
      if (alloc_op == MOP_STORE) begin
        ardy_d = alloc_aux_rdy || hit_alloc_aux;
        aval_d = alloc_aux_rdy ? alloc_aux_val : bc_data;
      end else begin
        ardy_d = 1'b1;
        aval_d = '0;
      end
      avld_d = 1'b0;
      iss_d  = 1'b0;
      done_d = 1'b0;
    end else if (valid_q) begin
      if (hit_base) begin
        brdy_d = 1'b1;
        bval_d = bc_data;
      end
      if (hit_aux) begin
        ardy_d = 1'b1;
        aval_d = bc_data;
      end
      if (brdy_q && !avld_q) begin
        avld_d = 1'b1;
        addr_d = bval_q + {{EXT_W{imm_q[IMM_W-1]}}, imm_q};
      end
      if (issue_en) begin
        iss_d = 1'b1;
        if (op_q == MOP_STORE) done_d = 1'b1;
      end
      if (resp_en) done_d = 1'b1;
      if (free_en) valid_d = 1'b0;
    end
  end

  assign pay_en = alloc_en || valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0; brdy_q <= 1'b0; ardy_q <= 1'b0;
      avld_q  <= 1'b0; iss_q  <= 1'b0; done_q <= 1'b0;
    end else begin
      valid_q <= valid_d; brdy_q <= brdy_d; ardy_q <= ardy_d;
      avld_q  <= avld_d;  iss_q  <= iss_d;  done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (pay_en) begin
      op_q   <= op_d;   btag_q <= btag_d; atag_q <= atag_d;
      bval_q <= bval_d; aval_q <= aval_d; addr_q <= addr_d; imm_q <= imm_d;
    end
  end

  assign e_valid    = valid_q;
  assign e_store    = (op_q == MOP_STORE);
  assign e_addr_vld = avld_q;
  assign e_addr     = addr_q;
  assign e_dat_rdy  = ardy_q;
  assign e_dat      = aval_q;
  assign e_tag      = atag_q;
  assign e_issued   = iss_q;
  assign e_done     = done_q;
endmodule

// File: rtl/lsq_ptrs.sv
`timescale 1ns/1ps
module lsq_ptrs #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = tail_q + PTR_W'(1);
    if (pop)  head_d = head_q + PTR_W'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (push || pop) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/lsq_hazard.sv
`timescale 1ns/1ps
module lsq_hazard #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [PTR_W-1:0]  head,
  input  logic [DEPTH-1:0]  e_valid,
  input  logic [DEPTH-1:0]  e_store,
  input  logic [DEPTH-1:0]  e_addr_vld,
  input  logic [DATA_W-1:0] e_addr [DEPTH],
  input  logic [DEPTH-1:0]  e_dat_rdy,
  input  logic [DEPTH-1:0]  e_issued,
  input  logic [DEPTH-1:0]  e_done,
  output logic [DEPTH-1:0]  eligible
);
  logic [PTR_W-1:0] age [DEPTH];
  logic [DEPTH-1:0] blocked;

  for (genvar g = 0; g < DEPTH; g++) begin : g_age
    assign age[g] = PTR_W'(g) - head;
  end

  // a load is blocked by any older, unissued store with unknown or equal address
  always_comb begin
    blocked = '0;
    for (int i = 0; i < DEPTH; i++) begin
      for (int j = 0; j < DEPTH; j++) begin
        if ((j != i) && e_valid[j] && e_store[j] && !e_done[j] &&
            (age[j] < age[i]) &&
            (!e_addr_vld[j] || (e_addr[j] == e_addr[i])))
          blocked[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_elig
    assign eligible[g] = e_valid[g] && e_addr_vld[g] && !e_issued[g] &&
                         (e_store[g] ? (e_dat_rdy[g] && (age[g] == '0))
                                     : !blocked[g]);
  end
endmodule

// File: rtl/lsq_pick.sv
`timescale 1ns/1ps
module lsq_pick #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] eligible,
  input  logic [PTR_W-1:0] head,
  output logic             gnt_vld,
  output logic [PTR_W-1:0] gnt_idx
);
  // scan from youngest to oldest so the oldest eligible entry wins
  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (eligible[head + PTR_W'(k)]) begin
        gnt_vld = 1'b1;
        gnt_idx = head + PTR_W'(k);
      end
    end
  end
endmodule

// File: rtl/lsq_core.sv
`timescale 1ns/1ps
module lsq_core #(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic              alloc_is_store,
  input  logic [TAG_W-1:0]  alloc_base_tag,
  input  logic              alloc_base_rdy,
  input  logic [DATA_W-1:0] alloc_base_val,
  input  logic [IMM_W-1:0]  alloc_imm,
  input  logic [TAG_W-1:0]  alloc_aux_tag,
  input  logic              alloc_aux_rdy,
  input  logic [DATA_W-1:0] alloc_aux_val,
  output logic              lsq_full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_store,
  output logic [DATA_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic [TAG_W-1:0]  mem_req_tag,
  output logic [PTR_W-1:0]  mem_req_idx,
  input  logic              mem_resp_valid,
  input  logic [PTR_W-1:0]  mem_resp_idx,
  output logic              ld_wb_valid,
  output logic [TAG_W-1:0]  ld_wb_tag
);
  import lsq_pkg::*;

  logic [PTR_W-1:0] head_ptr, tail_ptr, gnt_idx;
  logic [CNT_W-1:0] occ_cnt;
  logic             full_w, alloc_fire, free_fire, req_fire, gnt_vld;

  logic [DEPTH-1:0]  ent_valid, ent_store, ent_addr_vld, ent_dat_rdy;
  logic [DEPTH-1:0]  ent_issued, ent_done, ent_elig;
  logic [DATA_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_dat  [DEPTH];
  logic [TAG_W-1:0]  ent_tag  [DEPTH];

  mop_e alloc_op;
  assign alloc_op   = alloc_is_store ? MOP_STORE : MOP_LOAD;
  assign alloc_fire = alloc_valid && !full_w;
  assign free_fire  = ent_valid[head_ptr] && ent_done[head_ptr];
  assign req_fire   = gnt_vld && mem_req_ready;

  lsq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (alloc_fire),
    .pop   (free_fire),
    .head  (head_ptr),
    .tail  (tail_ptr),
    .count (occ_cnt),
    .full  (full_w)
  );

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    lsq_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) u_ent (
      .clk            (clk),
      .rst_n          (rst_n),
      .alloc_en       (alloc_fire && (tail_ptr == PTR_W'(g))),
      .alloc_op       (alloc_op),
      .alloc_base_tag (alloc_base_tag),
      .alloc_base_rdy (alloc_base_rdy),
      .alloc_base_val (alloc_base_val),
      .alloc_imm      (alloc_imm),
      .alloc_aux_tag  (alloc_aux_tag),
      .alloc_aux_rdy  (alloc_aux_rdy),
      .alloc_aux_val  (alloc_aux_val),
      .bc_valid       (bc_valid),
      .bc_tag         (bc_tag),
      .bc_data        (bc_data),
      .issue_en       (req_fire && (gnt_idx == PTR_W'(g))),
      .resp_en        (mem_resp_valid && (mem_resp_idx == PTR_W'(g))),
      .free_en        (free_fire && (head_ptr == PTR_W'(g))),
      .e_valid        (ent_valid[g]),
      .e_store        (ent_store[g]),
      .e_addr_vld     (ent_addr_vld[g]),
      .e_addr         (ent_addr[g]),
      .e_dat_rdy      (ent_dat_rdy[g]),
      .e_dat          (ent_dat[g]),
      .e_tag          (ent_tag[g]),
      .e_issued       (ent_issued[g]),
      .e_done         (ent_done[g])
    );
  end

  lsq_hazard #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_haz (
    .head       (head_ptr),
    .e_valid    (ent_valid),
    .e_store    (ent_store),
    .e_addr_vld (ent_addr_vld),
    .e_addr     (ent_addr),
    .e_dat_rdy  (ent_dat_rdy),
    .e_issued   (ent_issued),
    .e_done     (ent_done),
    .eligible   (ent_elig)
  );

  lsq_pick #(.DEPTH(DEPTH)) u_pick (
    .eligible (ent_elig),
    .head     (head_ptr),
    .gnt_vld  (gnt_vld),
    .gnt_idx  (gnt_idx)
  );

  assign lsq_full      = full_w;
  assign mem_req_valid = gnt_vld;
  assign mem_req_idx   = gnt_idx;
  assign mem_req_store = ent_store[gnt_idx];
  assign mem_req_addr  = ent_addr[gnt_idx];
  assign mem_req_wdata = ent_dat[gnt_idx];
  assign mem_req_tag   = ent_tag[gnt_idx];
  assign ld_wb_valid   = mem_resp_valid;
  assign ld_wb_tag     = ent_tag[mem_resp_idx];
endmodule

// File: rtl/lsq_core_chk.sv
`timescale 1ns/1ps
module lsq_core_chk #(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             full,
  input logic [CNT_W-1:0] cnt,
  input logic [PTR_W-1:0] head,
  input logic             mem_req_valid,
  input logic             mem_req_store,
  input logic [PTR_W-1:0] mem_req_idx,
  input logic [DEPTH-1:0] ent_valid,
  input logic [DEPTH-1:0] ent_issued
);
  assert_full_no_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> (cnt <= $past(cnt)));

  assert_store_at_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_store) |-> (mem_req_idx == head));

  assert_req_unissued_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (ent_valid[mem_req_idx] && !ent_issued[mem_req_idx]));

  assert_count_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  assert_one_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> ({1'b0, $past(cnt)} <= ({1'b0, cnt} + (CNT_W+1)'(1))));
endmodule

bind lsq_core lsq_core_chk #(.DEPTH(DEPTH)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .full          (lsq_full),
  .cnt           (occ_cnt),
  .head          (head_ptr),
  .mem_req_valid (mem_req_valid),
  .mem_req_store (mem_req_store),
  .mem_req_idx   (mem_req_idx),
  .ent_valid     (ent_valid),
  .ent_issued    (ent_issued)
);

// File: tb/lsq_core_test.sv
`timescale 1ns/1ps
module lsq_core_test;
  localparam int DEPTH = 8, TAG_W = 6, DATA_W = 32, IMM_W = 12;
  localparam int PTR_W = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, alloc_is_store, alloc_base_rdy, alloc_aux_rdy;
  logic [TAG_W-1:0] alloc_base_tag, alloc_aux_tag, bc_tag, mem_req_tag, ld_wb_tag;
  logic [DATA_W-1:0] alloc_base_val, alloc_aux_val, bc_data, mem_req_addr, mem_req_wdata;
  logic [IMM_W-1:0] alloc_imm;
  logic lsq_full, bc_valid, mem_req_valid, mem_req_ready, mem_req_store;
  logic mem_resp_valid, ld_wb_valid;
  logic [PTR_W-1:0] mem_req_idx, mem_resp_idx;

  always #10 clk = ~clk;

  lsq_core #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W), .IMM_W(IMM_W)) uut (.*);

  typedef struct {
    logic              st;
    logic [DATA_W-1:0] addr;
    logic [DATA_W-1:0] wd;
    logic [TAG_W-1:0]  tag;
  } exp_t;
  exp_t exp_q[$];

  int n_checks = 0, n_fail = 0;
  bit finished = 1'b0;
  logic             pend_v [DEPTH];
  logic [TAG_W-1:0] pend_t [DEPTH];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: compares accepted requests against the scoreboard
  always @(negedge clk) begin
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2/R5/R6/R7 unexpected request", {32'b0, mem_req_addr}, 64'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(mem_req_store == e.st, "R11 request kind", {63'b0, mem_req_store}, {63'b0, e.st});
        chk(mem_req_addr == e.addr, "R4/R8 request address", {32'b0, mem_req_addr}, {32'b0, e.addr});
        chk(mem_req_tag == e.tag, "R11 request tag", {58'b0, mem_req_tag}, {58'b0, e.tag});
        if (e.st)
          chk(mem_req_wdata == e.wd, "R11 store data", {32'b0, mem_req_wdata}, {32'b0, e.wd});
        else begin
          pend_v[mem_req_idx] = 1'b1;
          pend_t[mem_req_idx] = mem_req_tag;
        end
      end
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic push_exp(input logic st, input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] wd, input logic [TAG_W-1:0] t);
    exp_t e;
    e.st = st; e.addr = a; e.wd = wd; e.tag = t;
    exp_q.push_back(e);
  endtask

  task automatic alloc(input logic st, input logic [TAG_W-1:0] bt, input logic br, input logic [DATA_W-1:0] bv,
                       input logic [IMM_W-1:0] imm, input logic [TAG_W-1:0] at, input logic ar, input logic [DATA_W-1:0] av);
    alloc_valid = 1'b1; alloc_is_store = st; alloc_base_tag = bt; alloc_base_rdy = br;
    alloc_base_val = bv; alloc_imm = imm; alloc_aux_tag = at; alloc_aux_rdy = ar; alloc_aux_val = av;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v);
    bc_valid = 1'b1; bc_tag = t; bc_data = v;
    tick();
    bc_valid = 1'b0;
  endtask

  task automatic expect_idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(!mem_req_valid, req, {63'b0, mem_req_valid}, 64'h0);
      tick();
    end
  endtask

  task automatic wait_drain(input string req);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 60) begin
      tick();
      guard++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 64'h0);
    exp_q.delete();
  endtask

  task automatic respond(input logic [TAG_W-1:0] t);
    int idx = -1;
    for (int i = 0; i < DEPTH; i++) if (pend_v[i] && pend_t[i] == t) idx = i;
    if (idx < 0) begin
      chk(1'b0, "R9 load not issued", 64'h0, {58'b0, t});
    end else begin
      mem_resp_valid = 1'b1;
      mem_resp_idx = PTR_W'(idx);
      @(negedge clk);
      chk(ld_wb_valid && ld_wb_tag == t, "R9 writeback tag", {57'b0, ld_wb_valid, ld_wb_tag}, {57'b1, t});
      pend_v[idx] = 1'b0;
      tick();
      mem_resp_valid = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin pend_v[i] = 1'b0; pend_t[i] = '0; end
    rst_n = 1'b0; alloc_valid = 1'b0; alloc_is_store = 1'b0; alloc_base_tag = '0;
    alloc_base_rdy = 1'b0; alloc_base_val = '0; alloc_imm = '0; alloc_aux_tag = '0;
    alloc_aux_rdy = 1'b0; alloc_aux_val = '0; bc_valid = 1'b0; bc_tag = '0; bc_data = '0;
    mem_req_ready = 1'b1; mem_resp_valid = 1'b0; mem_resp_idx = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    chk(!lsq_full, "R1 full after reset", {63'b0, lsq_full}, 64'h0);
    chk(!mem_req_valid, "R1 request after reset", {63'b0, mem_req_valid}, 64'h0);
    tick();

    // R4: address with negative offset, held while not ready
    mem_req_ready = 1'b0;
    alloc(1'b0, 6'd1, 1'b1, 32'h100, 12'hFFC, 6'd5, 1'b0, '0);
    tick();
    @(negedge clk);
    chk(mem_req_valid && mem_req_addr == 32'hFC, "R4 held request address", {32'b0, mem_req_addr}, 64'hFC);
    tick();
    @(negedge clk);
    chk(mem_req_valid, "R4 request held without ready", {63'b0, mem_req_valid}, 64'h1);
    tick();
    push_exp(1'b0, 32'hFC, '0, 6'd5);
    mem_req_ready = 1'b1;
    wait_drain("R4 load issue");
    respond(6'd5);

    // R3: broadcast in the allocation cycle
    push_exp(1'b0, 32'h508, '0, 6'd7);
    bc_valid = 1'b1; bc_tag = 6'd50; bc_data = 32'h500;
    alloc(1'b0, 6'd50, 1'b0, '0, 12'h008, 6'd7, 1'b0, '0);
    bc_valid = 1'b0;
    wait_drain("R3 same-cycle wakeup");
    respond(6'd7);

    // R5/R6/R7: load passes a resolved store at another address
    alloc(1'b1, 6'd10, 1'b0, '0, 12'h000, 6'd11, 1'b0, '0);
    alloc(1'b0, 6'd2, 1'b1, 32'h200, 12'h000, 6'd12, 1'b0, '0);
    expect_idle(4, "R5 load behind unknown store address");
    push_exp(1'b0, 32'h200, '0, 6'd12);
    bcast(6'd10, 32'h300);
    wait_drain("R6 load passes different address");
    expect_idle(3, "R7 store without data");
    push_exp(1'b1, 32'h300, 32'hABCD, 6'd11);
    bcast(6'd11, 32'hABCD);
    wait_drain("R3 R7 store after data wakeup");
    respond(6'd12);

    // R6: equal address waits for the store
    alloc(1'b1, 6'd3, 1'b1, 32'h400, 12'h000, 6'd13, 1'b0, '0);
    alloc(1'b0, 6'd4, 1'b1, 32'h3F0, 12'h010, 6'd14, 1'b0, '0);
    expect_idle(4, "R6 load behind matching store");
    push_exp(1'b1, 32'h400, 32'h55, 6'd13);
    push_exp(1'b0, 32'h400, '0, 6'd14);
    bcast(6'd13, 32'h55);
    wait_drain("R6 store then load");
    respond(6'd14);

    // R7: store waits for an older load to complete
    alloc(1'b0, 6'd20, 1'b0, '0, 12'h004, 6'd21, 1'b0, '0);
    alloc(1'b1, 6'd5, 1'b1, 32'h600, 12'h000, 6'd22, 1'b1, 32'h77);
    expect_idle(4, "R7 store not oldest");
    push_exp(1'b0, 32'h704, '0, 6'd21);
    bcast(6'd20, 32'h700);
    wait_drain("R3 load after wakeup");
    expect_idle(4, "R7 store behind issued load");
    push_exp(1'b1, 32'h600, 32'h77, 6'd22);
    respond(6'd21);
    wait_drain("R7 store after load left");

    // R8/R9: oldest first, responses out of order
    alloc(1'b0, 6'd30, 1'b0, '0, 12'h000, 6'd31, 1'b0, '0);
    alloc(1'b0, 6'd30, 1'b0, '0, 12'h010, 6'd32, 1'b0, '0);
    alloc(1'b0, 6'd30, 1'b0, '0, 12'h020, 6'd33, 1'b0, '0);
    push_exp(1'b0, 32'h800, '0, 6'd31);
    push_exp(1'b0, 32'h810, '0, 6'd32);
    push_exp(1'b0, 32'h820, '0, 6'd33);
    bcast(6'd30, 32'h800);
    wait_drain("R8 oldest-first order");
    respond(6'd32);
    respond(6'd31);
    respond(6'd33);
    tick(); tick(); tick();

    // R2/R10: fill, refuse, in-order freeing
    for (int k = 0; k < DEPTH; k++)
      alloc(1'b0, 6'd40, 1'b0, '0, IMM_W'(8 * k), TAG_W'(41 + k), 1'b0, '0);
    @(negedge clk);
    chk(lsq_full, "R2 full with all entries", {63'b0, lsq_full}, 64'h1);
    tick();
    alloc(1'b0, 6'd6, 1'b1, 32'h999, 12'h000, 6'd60, 1'b0, '0);
    @(negedge clk);
    chk(lsq_full, "R2 full after refused alloc", {63'b0, lsq_full}, 64'h1);
    tick();
    for (int k = 0; k < DEPTH; k++)
      push_exp(1'b0, 32'h900 + 32'(8 * k), '0, TAG_W'(41 + k));
    bcast(6'd40, 32'h900);
    wait_drain("R2 R8 eight loads, refused one absent");
    expect_idle(3, "R2 refused alloc never requests");
    for (int k = 1; k < DEPTH; k++) respond(TAG_W'(41 + k));
    tick();
    @(negedge clk);
    chk(lsq_full, "R10 head not done keeps queue full", {63'b0, lsq_full}, 64'h1);
    tick();
    respond(6'd41);
    tick();
    @(negedge clk);
    chk(!lsq_full, "R10 head freed", {63'b0, lsq_full}, 64'h0);
    tick();

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule